// File: doc/BRIEF.md
# Framed SPI Register Slave

This block is a single-lane SPI target that turns framed byte transactions from a host controller into accesses on an internal byte-wide storage port. A frame opens with an instruction byte, followed by a two-byte offset and one turnaround byte, and then carries data bytes until chip select goes high. The instruction selects one of four storage regions and says whether the data bytes are to be written or read. The four regions are a general register bank, a register bank for the first socket, a transmit buffer and a receive buffer.

The host uses SPI mode 0 with the most significant bit first. SCLK, MOSI and chip select are brought into the system clock domain through a synchronizer and edge-detected, so SCLK must run well below the system clock. The turnaround byte gives the block time to fetch the first read byte before the host clocks it out. The offset advances after every data byte, so one frame can move a whole burst. In the two buffer regions the offset wraps within the 4 KB window. The mode register of the socket bank keeps a MAC-filter enable bit that the host can set and read back.

Top module: `spi_regslave`

## Requirements
- R1: A frame is, in order: one instruction byte, a 16-bit offset, one ignored turnaround byte, then data bytes. A data byte written at an offset is returned by a later read frame at that offset.
- R2: The offset is sent high byte first. Offset 0x0A05 and offset 0x050A address different locations.
- R3: Instruction bit 5 set makes the frame a write. With bit 5 clear, the MOSI data bytes are ignored and storage is left unchanged.
- R4: Instruction bits [7:6] select the region: 00 general registers, 01 socket-0 registers, 10 transmit buffer, 11 receive buffer. The four regions do not alias each other.
- R5: Instruction bits [4:0] have no effect on the access.
- R6: During the data phase the offset rises by one after each byte, for both reads and writes. Exactly one storage write happens per written byte.
- R7: In the transmit and receive buffer regions the offset wraps from 0x0FFF to 0x0000 (the regions are 0x1000 bytes each).
- R8: The general and socket-0 banks each hold 64 bytes (offsets 0x00 to 0x3F). Writes at higher offsets are dropped without touching any other location, and reads there return 0x00.
- R9: Bit 7 of socket-0 offset 0x0000 (the mode register) is the MAC-filter enable. It resets to 0, and the value the host writes is read back.
- R10: Raising chip select at any point abandons the frame. An unfinished byte is never written, and the next frame starts again at its instruction byte.
- R11: The MISO output enable is low while chip select is high and high while a frame is in progress. Read data for the first data byte is present before the first data-phase SCLK rising edge.
- R12: After reset every byte of both register banks reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host, MSB first |
| miso | output | 1 | Serial data to the host, changes after SCLK falling edges |
| miso_oe | output | 1 | Output enable for the MISO pad driver |

## Verification
Both register banks are swept across their whole range with one burst write and one burst read. This separates correct offset stepping from stuck or skipped offsets, and a second sweep confirms the reset contents are zero. The same offset is written in all four regions with distinct values, which separates correct region decoding from aliasing. Every value of the ignored instruction bits is tried. Mirrored high and low offset bytes show up any swapped byte order. Bursts that straddle the end of a bank or the end of a buffer separate correct dropping and wrapping from aliasing onto low offsets. Frames cut short in the offset phase and in the middle of a data byte, together with read frames that carry junk on MOSI, show that nothing is stored by mistake.

// File: rtl/spi_regslave_pkg.sv
`timescale 1ns/1ps
package spi_regslave_pkg;
   // region select, instruction bits [7:6]
   typedef enum logic [1:0] {
      BLK_COMMON = 2'b00,
      BLK_SOCK   = 2'b01,
      BLK_TXBUF  = 2'b10,
      BLK_RXBUF  = 2'b11
   } blk_e;

   typedef enum logic [2:0] {
      PH_INSTR,
      PH_ADDR_HI,
      PH_ADDR_LO,
      PH_DUMMY,
      PH_DATA
   } phase_e;

   localparam int unsigned WR_BIT = 5;
endpackage

// File: rtl/spi_regslave_sync.sv
`timescale 1ns/1ps
module spi_regslave_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_regslave_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_regslave_frame.sv
`timescale 1ns/1ps
module spi_regslave_frame
   import spi_regslave_pkg::*;
#(
   parameter int unsigned BUF_SIZE = 4096
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sclk_s,
   input  logic        mosi_s,
   input  logic        cs_act,
   output blk_e        mem_blk,
   output logic [15:0] mem_off,
   output logic [7:0]  mem_wdata,
   output logic        mem_we,
   input  logic [7:0]  mem_rdata,
   output logic        miso,
   output logic        miso_oe,
   output phase_e      phase_o
);
   localparam logic [15:0] BUF_MASK = 16'(BUF_SIZE - 1);

   logic        sclk_d;
   logic [2:0]  bit_cnt;
   logic [6:0]  shreg;
   phase_e      phase;
   blk_e        blk;
   logic        is_wr;
   logic [15:0] offset;
   logic [15:0] next_off;
   logic [7:0]  rd_q;
   logic        fetch_q;
   logic        miso_q;
   logic        oe_q;

   logic        rise, fall, byte_done;
   logic [7:0]  byte_in;

   assign rise      = cs_act &  sclk_s & ~sclk_d;
   assign fall      = cs_act & ~sclk_s &  sclk_d;
   assign byte_in   = {shreg, mosi_s};
   assign byte_done = rise && (bit_cnt == 3'd7);

   always_comb begin
      next_off = offset + 16'd1;
      if (blk == BLK_TXBUF || blk == BLK_RXBUF) next_off = next_off & BUF_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         phase   <= PH_INSTR;
         blk     <= BLK_COMMON;
         is_wr   <= 1'b0;
         offset  <= '0;
         rd_q    <= '0;
         fetch_q <= 1'b0;
         miso_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         oe_q    <= cs_act;
         fetch_q <= 1'b0;
         if (fetch_q) rd_q <= mem_rdata;
         if (!cs_act) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            miso_q  <= 1'b0;
         end else begin
            if (rise) begin
               shreg   <= byte_in[6:0];
               bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
               case (phase)
                  PH_INSTR: begin
                     blk   <= blk_e'(byte_in[7:6]);
                     is_wr <= byte_in[WR_BIT];
                     phase <= PH_ADDR_HI;
                  end
                  PH_ADDR_HI: begin
                     offset[15:8] <= byte_in;
                     phase        <= PH_ADDR_LO;
                  end
                  PH_ADDR_LO: begin
                     offset[7:0] <= byte_in;
                     phase       <= PH_DUMMY;
                     fetch_q     <= 1'b1;
                  end
                  PH_DUMMY: phase <= PH_DATA;
                  default: begin
                     offset  <= next_off;
                     fetch_q <= 1'b1;
                  end
               endcase
            end
            if (fall) miso_q <= (phase == PH_DATA && !is_wr) ? rd_q[~bit_cnt] : 1'b0;
         end
      end
   end

   assign mem_blk   = blk;
   assign mem_off   = offset;
   assign mem_wdata = byte_in;
   assign mem_we    = byte_done && (phase == PH_DATA) && is_wr;
   assign miso      = miso_q;
   assign miso_oe   = oe_q;
   assign phase_o   = phase;
endmodule

// File: rtl/spi_regslave_store.sv
`timescale 1ns/1ps
module spi_regslave_store
   import spi_regslave_pkg::*;
#(
   parameter int unsigned COMMON_SIZE = 64,
   parameter int unsigned SOCK_SIZE   = 64,
   parameter int unsigned BUF_SIZE    = 4096,
   parameter int unsigned BUF_DEPTH   = 1024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  blk_e        blk,
   input  logic [15:0] off,
   input  logic [7:0]  wdata,
   input  logic        we,
   output logic [7:0]  rdata
);
   localparam int unsigned BUF_AW = $clog2(BUF_DEPTH);

   if (BUF_DEPTH > BUF_SIZE || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0 || BUF_DEPTH < 2)
   begin : g_bad_buf
      $error("spi_regslave_store: BUF_DEPTH must be a power of two not above BUF_SIZE");
   end

   logic [7:0] bank_rd [4];

   // register banks: reset flops, bounded offset range
   for (genvar b = 0; b < 2; b++) begin : g_reg
      localparam int unsigned SZ = (b == 0) ? COMMON_SIZE : SOCK_SIZE;
      localparam int unsigned AW = $clog2(SZ);
      if (SZ < 2 || (SZ & (SZ - 1)) != 0 || SZ > 65536) begin : g_bad_sz
         $error("spi_regslave_store: register bank size must be a power of two");
      end
      logic [7:0] regs [SZ];
      logic       hit;
      assign hit = (blk == blk_e'(2'(b))) && ({16'd0, off} < 32'(SZ));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(SZ); i++) regs[i] <= '0;
         end else if (we && hit) begin
            regs[off[AW-1:0]] <= wdata;
         end
      end
      assign bank_rd[b] = hit ? regs[off[AW-1:0]] : 8'h00;
   end

   // packet buffers: plain arrays, offset reduced to the implemented depth
   for (genvar b = 2; b < 4; b++) begin : g_buf
      logic [7:0] mem [BUF_DEPTH];
      logic       hit;
      assign hit = (blk == blk_e'(2'(b)));
      always_ff @(posedge clk) begin
         if (we && hit) mem[off[BUF_AW-1:0]] <= wdata;
      end
      assign bank_rd[b] = mem[off[BUF_AW-1:0]];
   end

   assign rdata = bank_rd[blk];
endmodule

// File: rtl/spi_regslave.sv
`timescale 1ns/1ps
module spi_regslave
   import spi_regslave_pkg::*;
#(
   parameter int unsigned COMMON_SIZE = 64,
   parameter int unsigned SOCK_SIZE   = 64,
   parameter int unsigned BUF_SIZE    = 4096,
   parameter int unsigned BUF_DEPTH   = 1024,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic miso,
   output logic miso_oe
);
   if (BUF_SIZE < 2 || BUF_SIZE > 65536 || (BUF_SIZE & (BUF_SIZE - 1)) != 0) begin : g_bad_bsz
      $error("spi_regslave: BUF_SIZE must be a power of two up to 64K");
   end

   logic [2:0]  pins_s;
   logic        sclk_s, mosi_s, cs_act;
   blk_e        mem_blk;
   logic [15:0] mem_off;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_we;
   phase_e      phase_w;

   spi_regslave_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, mosi, ~cs_n}),
      .q     (pins_s)
   );
   assign {sclk_s, mosi_s, cs_act} = pins_s;

   spi_regslave_frame #(.BUF_SIZE(BUF_SIZE)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .mosi_s    (mosi_s),
      .cs_act    (cs_act),
      .mem_blk   (mem_blk),
      .mem_off   (mem_off),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .miso      (miso),
      .miso_oe   (miso_oe),
      .phase_o   (phase_w)
   );

   spi_regslave_store #(
      .COMMON_SIZE (COMMON_SIZE),
      .SOCK_SIZE   (SOCK_SIZE),
      .BUF_SIZE    (BUF_SIZE),
      .BUF_DEPTH   (BUF_DEPTH)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .blk   (mem_blk),
      .off   (mem_off),
      .wdata (mem_wdata),
      .we    (mem_we),
      .rdata (mem_rdata)
   );
endmodule

// File: rtl/spi_regslave_chk.sv
`timescale 1ns/1ps
module spi_regslave_chk
   import spi_regslave_pkg::*;
#(
   parameter int unsigned COMMON_SIZE = 64,
   parameter int unsigned SOCK_SIZE   = 64,
   parameter int unsigned BUF_SIZE    = 4096,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        miso_oe,
   input logic        cs_act,
   input phase_e      phase,
   input logic        mem_we,
   input blk_e        mem_blk,
   input logic [15:0] mem_off,
   input logic [7:0]  mem_rdata
);
   logic [7:0] hi_cnt;
   logic       reg_blk;
   logic       oob;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_cnt <= '0;
      else if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
   end

   assign reg_blk = (mem_blk == BLK_COMMON) || (mem_blk == BLK_SOCK);
   assign oob = reg_blk &&
                ({16'd0, mem_off} >= ((mem_blk == BLK_COMMON) ? 32'(COMMON_SIZE) : 32'(SOCK_SIZE)));

   // R11: pad driver off once chip select has been high long enough to cross the synchronizer
   assert_oe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(hi_cnt) > SYNC_STAGES) |-> !miso_oe);

   // R10: deselect returns the frame to the instruction phase
   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (phase == PH_INSTR));

   // R6: register-bank offset steps by one after a written byte
   assert_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && reg_blk) |=> (mem_off == 16'($past(mem_off) + 16'd1)));

   // R6: one storage write per byte
   assert_one_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R7: buffer offset wraps at the window end
   assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !reg_blk && (mem_off == 16'(BUF_SIZE - 1))) |=> (mem_off == 16'd0));

   // R8: out-of-range register offsets read as zero
   assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oob |-> (mem_rdata == 8'h00));
endmodule

bind spi_regslave spi_regslave_chk #(
   .COMMON_SIZE (COMMON_SIZE),
   .SOCK_SIZE   (SOCK_SIZE),
   .BUF_SIZE    (BUF_SIZE),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .miso_oe   (miso_oe),
   .cs_act    (cs_act),
   .phase     (phase_w),
   .mem_we    (mem_we),
   .mem_blk   (mem_blk),
   .mem_off   (mem_off),
   .mem_rdata (mem_rdata)
);

// File: tb/sim_spi_regslave.sv
`timescale 1ns/1ps
module sim_spi_regslave;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso, miso_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] cexp [64];
   logic [7:0] sexp [64];

   always #2.5 clk = ~clk;  // 200 MHz

   spi_regslave #(.BUF_DEPTH(4096)) u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
      .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
   );

   function automatic logic [7:0] mk_instr(input logic [1:0] blk, input logic wr, input logic [4:0] junk);
      return {blk, wr, junk};
   endfunction

   function automatic logic [7:0] pat(input logic [1:0] blk, input int off);
      return 8'(off * 7 + 19 + int'(blk) * 64);
   endfunction

   task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
      end
   endtask

   task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = tx[i];
         #30;
         rx[i] = miso;
         sclk = 1'b1;
         #30;
         sclk = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      xfer_bits(tx, 8, rx);
   endtask

   task automatic frame_begin(input logic [7:0] instr, input logic [15:0] off);
      logic [7:0] r;
      cs_n = 1'b0;
      #20;
      xfer(instr, r);
      xfer(off[15:8], r);
      xfer(off[7:0], r);
      xfer(8'h00, r);
   endtask

   task automatic frame_end;
      #20 cs_n = 1'b1;
      #80;
   endtask

   task automatic wr1(input logic [1:0] blk, input logic [15:0] off, input logic [7:0] d);
      logic [7:0] r;
      frame_begin(mk_instr(blk, 1'b1, 5'h00), off);
      xfer(d, r);
      frame_end();
   endtask

   task automatic rd1(input logic [1:0] blk, input logic [15:0] off, output logic [7:0] d);
      frame_begin(mk_instr(blk, 1'b0, 5'h00), off);
      xfer(8'h00, d);
      frame_end();
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      #23 rst_n = 1'b1;
      #40;

      // R11: idle output enable
      total++;
      if (miso_oe !== 1'b0) begin bad++; $display("FAIL R11 actual=%b expected=0", miso_oe); end

      // R12: reset contents of both banks, swept by burst reads
      frame_begin(mk_instr(2'b00, 1'b0, 5'h00), 16'h0000);
      total++;
      if (miso_oe !== 1'b1) begin bad++; $display("FAIL R11 actual=%b expected=1", miso_oe); end
      for (int i = 0; i < 64; i++) begin xfer(8'h00, r); check8(r, 8'h00, "R12 common"); end
      frame_end();
      frame_begin(mk_instr(2'b01, 1'b0, 5'h00), 16'h0000);
      for (int i = 0; i < 64; i++) begin xfer(8'h00, r); check8(r, 8'h00, "R12 socket"); end
      frame_end();

      // R9: MAC-filter enable defaults off, then set and cleared
      rd1(2'b01, 16'h0000, r); check8(r & 8'h80, 8'h00, "R9 reset");
      wr1(2'b01, 16'h0000, 8'h80);
      rd1(2'b01, 16'h0000, r); check8(r, 8'h80, "R9 set");
      wr1(2'b01, 16'h0000, 8'h00);
      rd1(2'b01, 16'h0000, r); check8(r, 8'h00, "R9 clear");

      // R1 R6: full-range burst write then burst read of both banks
      for (int b = 0; b < 2; b++) begin
         frame_begin(mk_instr(2'(b), 1'b1, 5'h00), 16'h0000);
         for (int i = 0; i < 64; i++) begin
            xfer(pat(2'(b), i), r);
            if (b == 0) cexp[i] = pat(2'(b), i); else sexp[i] = pat(2'(b), i);
         end
         frame_end();
         frame_begin(mk_instr(2'(b), 1'b0, 5'h00), 16'h0000);
         for (int i = 0; i < 64; i++) begin
            xfer(8'h00, r);
            check8(r, (b == 0) ? cexp[i] : sexp[i], "R1 R6 burst");
         end
         frame_end();
      end
      rd1(2'b00, 16'h0021, r); check8(r, cexp[33], "R1 single read");

      // R8: burst straddling the bank end, upper bytes dropped, no alias onto offset 0/1
      frame_begin(mk_instr(2'b00, 1'b1, 5'h00), 16'h003E);
      xfer(8'hE1, r); xfer(8'hE2, r); xfer(8'hE3, r); xfer(8'hE4, r);
      frame_end();
      cexp[62] = 8'hE1; cexp[63] = 8'hE2;
      rd1(2'b00, 16'h003F, r); check8(r, 8'hE2, "R8 last in range");
      rd1(2'b00, 16'h0040, r); check8(r, 8'h00, "R8 read beyond");
      rd1(2'b00, 16'h0041, r); check8(r, 8'h00, "R8 read beyond");
      rd1(2'b00, 16'h0000, r); check8(r, cexp[0], "R8 no alias");
      rd1(2'b00, 16'h0001, r); check8(r, cexp[1], "R8 no alias");
      wr1(2'b01, 16'h8000, 8'h5A);
      rd1(2'b01, 16'h0000, r); check8(r, sexp[0], "R8 socket no alias");

      // R4: same offset in all four regions
      for (int b = 0; b < 4; b++) wr1(2'(b), 16'h0010, 8'hA0 + 8'(b));
      for (int b = 0; b < 4; b++) begin
         rd1(2'(b), 16'h0010, r); check8(r, 8'hA0 + 8'(b), "R4 region");
      end
      cexp[16] = 8'hA0; sexp[16] = 8'hA1;

      // R2: byte order of the offset
      wr1(2'b10, 16'h0A05, 8'h3C);
      wr1(2'b10, 16'h050A, 8'hC3);
      rd1(2'b10, 16'h0A05, r); check8(r, 8'h3C, "R2 hi-first");
      rd1(2'b10, 16'h050A, r); check8(r, 8'hC3, "R2 hi-first");

      // R7: wrap in the receive buffer
      frame_begin(mk_instr(2'b11, 1'b1, 5'h00), 16'h0FFE);
      xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); xfer(8'h44, r);
      frame_end();
      rd1(2'b11, 16'h0000, r); check8(r, 8'h33, "R7 wrap write");
      rd1(2'b11, 16'h0001, r); check8(r, 8'h44, "R7 wrap write");
      frame_begin(mk_instr(2'b11, 1'b0, 5'h00), 16'h0FFF);
      xfer(8'h00, r); check8(r, 8'h22, "R7 wrap read");
      xfer(8'h00, r); check8(r, 8'h33, "R7 wrap read");
      frame_end();

      // R3: read frame with junk on MOSI leaves storage intact
      frame_begin(mk_instr(2'b00, 1'b0, 5'h00), 16'h0005);
      xfer(8'hFF, r); check8(r, cexp[5], "R3 read data");
      xfer(8'hFF, r); check8(r, cexp[6], "R3 read data");
      frame_end();
      rd1(2'b00, 16'h0005, r); check8(r, cexp[5], "R3 not written");
      rd1(2'b00, 16'h0006, r); check8(r, cexp[6], "R3 not written");

      // R5: every value of the ignored instruction bits
      for (int j = 0; j < 32; j++) begin
         frame_begin(mk_instr(2'b10, 1'b1, 5'(j)), 16'(256 + j));
         xfer(8'(j) ^ 8'h5A, r);
         frame_end();
      end
      for (int j = 0; j < 32; j++) begin
         frame_begin(mk_instr(2'b10, 1'b0, 5'(31 - j)), 16'(256 + j));
         xfer(8'h00, r);
         frame_end();
         check8(r, 8'(j) ^ 8'h5A, "R5 junk bits");
      end

      // R10: abort inside the offset phase
      cs_n = 1'b0; #20;
      xfer(mk_instr(2'b00, 1'b1, 5'h00), r);
      xfer(8'h00, r);
      frame_end();
      rd1(2'b00, 16'h0007, r); check8(r, cexp[7], "R10 abort in offset");
      // R10: abort mid data byte
      frame_begin(mk_instr(2'b00, 1'b1, 5'h00), 16'h0008);
      xfer(8'h77, r);
      xfer_bits(8'h99, 4, r);
      frame_end();
      rd1(2'b00, 16'h0008, r); check8(r, 8'h77, "R10 full byte kept");
      rd1(2'b00, 16'h0009, r); check8(r, cexp[9], "R10 partial byte dropped");

      total++;
      if (miso_oe !== 1'b0) begin bad++; $display("FAIL R11 actual=%b expected=0", miso_oe); end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule